// File: doc/BRIEF.md
# Byte-Wide Bidirectional Transceiver with Parity Generator and Checker

This block moves one byte between two buses, A and B, in the direction chosen by a direction input, and adds parity protection on the way. When it sends A to B, it drives a parity bit that it generates from the A byte. When it sends B to A, the same parity pin becomes an input. The block checks it against the B byte and drives a status flag that is high when the parity is correct and low when it is not. An odd/even select sets the parity sense. An active-low enable releases every pin the block can drive.

Each pin that can be tri-stated is brought out as a separate input value, output value and drive enable, so the block fits a fully synthesizable flow. The pad level joins these into real bidirectional nets. A parameter sets whether all outputs and enables pass straight through or go through one register stage. That register stage uses an asynchronous active-low reset that is released in step with the clock. The default build uses the register stage.

Top module: `bidir_parity_xcvr`

## Requirements
- R1: With the enable active (`oe_n` low) and `dir` = 1 (A to B), `b_drv` is 1, `a_drv` is 0, and `b_out` equals `a_in` bit for bit, without inversion.
- R2: With the enable active and `dir` = 0 (B to A), `a_drv` is 1, `b_drv` is 0, and `a_out` equals `b_in` bit for bit, without inversion.
- R3: With `oe_n` high, `a_drv`, `b_drv`, `par_drv` and `err_drv` are all 0, whatever the other inputs are.
- R4: With the enable active and `dir` = 1, `par_drv` is 1, `err_drv` is 0, and `par_out` = `odd_sel` XOR (count of ones in `a_in`, modulo 2). So with `odd_sel` = 1 and an even count, `par_out` is 1. The parity input has no effect in this mode.
- R5: With the enable active and `dir` = 0, `err_drv` is 1, `par_drv` is 0, and `err_n_out` = NOT(`par_in` XOR `odd_sel` XOR (count of ones in `b_in`, modulo 2)). A value of 1 means no error.
- R6: Receive example: `b_in` with an even count of ones, `odd_sel` = 1 and `par_in` = 1 give `err_n_out` = 1. The same settings with an odd count of ones give `err_n_out` = 0.
- R7: `a_drv` and `b_drv` are never 1 together, and `par_drv` and `err_drv` are never 1 together.
- R8: With `STAGES` = 1, the outputs show the inputs that were present at the previous rising clock edge. While `rst_n` is low every drive enable is 0, and it goes to 0 at once when `rst_n` falls, without waiting for a clock edge. After `rst_n` rises, the outputs follow the inputs from the third rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| oe_n | input | 1 | Active-low enable for all driven pins |
| dir | input | 1 | Transfer direction: 1 = A to B, 0 = B to A |
| odd_sel | input | 1 | Parity sense select |
| a_in | input | W | Value sensed on bus A |
| a_out | output | W | Value to drive on bus A |
| a_drv | output | 1 | Drive enable for bus A |
| b_in | input | W | Value sensed on bus B |
| b_out | output | W | Value to drive on bus B |
| b_drv | output | 1 | Drive enable for bus B |
| par_in | input | 1 | Value sensed on the parity pin |
| par_out | output | 1 | Generated parity to drive on the parity pin |
| par_drv | output | 1 | Drive enable for the parity pin |
| err_n_out | output | 1 | Check result, low on parity error |
| err_drv | output | 1 | Drive enable for the check result pin |

## Verification
In transmit, every one of the 256 A bytes is tried with both select values. This separates a correct modulo-2 count from an error on any single bit and from an inverted sense. In receive, every B byte is tried with all four combinations of select and parity input, so each of the three terms of the check is seen to toggle the flag on its own. The disabled patterns change the data and parity inputs while the enable is high, to show that no pin is driven. A reset applied between clock edges in the middle of the run shows the enables dropping at once and the latency coming back after release.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    XFER_B2A = 1'b0,
    XFER_A2B = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic a;
    logic b;
    logic par;
    logic err;
  } drv_set_t;

  localparam int DRV_BITS = $bits(drv_set_t);

endpackage

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_bits,
  input  logic [W-1:0] b_bits,
  input  logic         odd_sel,
  input  logic         par_in,
  output logic         gen_par,
  output logic         chk_ok
);

  logic [W:0] a_fold;
  logic [W:0] b_fold;

  assign a_fold[0] = 1'b0;
  assign b_fold[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fold
    assign a_fold[i+1] = a_fold[i] ^ a_bits[i];
    assign b_fold[i+1] = b_fold[i] ^ b_bits[i];
  end

  assign gen_par = odd_sel ^ a_fold[W];
  assign chk_ok  = ~(b_fold[W] ^ par_in ^ odd_sel);

endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import xcvr_pkg::*;
(
  input  logic     oe_n,
  input  logic     dir,
  output drv_set_t drv
);

  xfer_dir_e mode;
  logic      active;

  assign mode   = xfer_dir_e'(dir);
  assign active = ~oe_n;

  always_comb begin
    drv     = '0;
    if (active) begin
      if (mode == XFER_A2B) begin
        drv.b   = 1'b1;
        drv.par = 1'b1;
      end else begin
        drv.a   = 1'b1;
        drv.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage #(
  parameter int PW     = 22,
  parameter int STAGES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);

  if (STAGES == 0) begin : g_pass
    assign q = d;
  end else begin : g_reg
    logic          rs_meta;
    logic          rs_sync;
    logic [PW-1:0] q_r;
    logic [PW-1:0] q_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rs_meta <= 1'b0;
        rs_sync <= 1'b0;
      end else begin
        rs_meta <= 1'b1;
        rs_sync <= rs_meta;
      end
    end

    always_comb begin
      q_nxt = d;
    end

    always_ff @(posedge clk or negedge rs_sync) begin
      if (!rs_sync) begin
        q_r <= '0;
      end else begin
        q_r <= q_nxt;
      end
    end

    assign q = q_r;
  end

endmodule

// File: rtl/bidir_parity_xcvr.sv
module bidir_parity_xcvr
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         odd_sel,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         par_in,
  output logic         par_out,
  output logic         par_drv,
  output logic         err_n_out,
  output logic         err_drv
);

  localparam int PW = DRV_BITS + 2 * W + 2;

  drv_set_t      drv_c;
  drv_set_t      drv_q;
  logic          gen_par;
  logic          chk_ok;
  logic [PW-1:0] pack_c;
  logic [PW-1:0] pack_q;
  logic [W-1:0]  a_out_q;
  logic [W-1:0]  b_out_q;
  logic          par_q;
  logic          err_q;

  xcvr_parity #(.W(W)) u_parity (
    .a_bits  (a_in),
    .b_bits  (b_in),
    .odd_sel (odd_sel),
    .par_in  (par_in),
    .gen_par (gen_par),
    .chk_ok  (chk_ok)
  );

  xcvr_drive_ctrl u_drive (
    .oe_n (oe_n),
    .dir  (dir),
    .drv  (drv_c)
  );

  assign pack_c = {drv_c, b_in, a_in, gen_par, chk_ok};

  xcvr_out_stage #(.PW(PW), .STAGES(STAGES)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pack_c),
    .q     (pack_q)
  );

  assign {drv_q, a_out_q, b_out_q, par_q, err_q} = pack_q;

  assign a_out     = a_out_q;
  assign b_out     = b_out_q;
  assign par_out   = par_q;
  assign err_n_out = err_q;
  assign a_drv     = drv_q.a;
  assign b_drv     = drv_q.b;
  assign par_drv   = drv_q.par;
  assign err_drv   = drv_q.err;

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_n,
  input logic         dir,
  input logic         odd_sel,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic         par_in,
  input logic         par_out,
  input logic         par_drv,
  input logic         err_n_out,
  input logic         err_drv
);

  logic [1:0] live_cnt;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= 2'd0;
    end else if (live_cnt != 2'd3) begin
      live_cnt <= live_cnt + 2'd1;
    end
  end

  assign ready = (live_cnt == 2'd3);

  // R7: no two enables fight on one net
  p_bus_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drv && b_drv));
  p_pin_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_drv && err_drv));

  if (STAGES != 0) begin : g_seq
    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(oe_n) |-> !(a_drv || b_drv || par_drv || err_drv));
    p_a2b_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(!oe_n && dir) |-> b_drv && !a_drv && (b_out == $past(a_in)));
    p_b2a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(!oe_n && !dir) |-> a_drv && !b_drv && (a_out == $past(b_in)));
    p_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(!oe_n && dir) |->
        par_drv && !err_drv && (par_out == ($past(odd_sel) ^ $past(^a_in))));
    p_chk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(!oe_n && !dir) |->
        err_drv && !par_drv &&
        (err_n_out == !($past(^b_in) ^ $past(par_in) ^ $past(odd_sel))));
  end else begin : g_comb
    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !(a_drv || b_drv || par_drv || err_drv));
    p_a2b_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n && dir |-> b_drv && !a_drv && (b_out == a_in));
    p_b2a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n && !dir |-> a_drv && !b_drv && (a_out == b_in));
  end

endmodule

bind bidir_parity_xcvr xcvr_checker #(.W(W), .STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_n      (oe_n),
  .dir       (dir),
  .odd_sel   (odd_sel),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_drv     (a_drv),
  .b_in      (b_in),
  .b_out     (b_out),
  .b_drv     (b_drv),
  .par_in    (par_in),
  .par_out   (par_out),
  .par_drv   (par_drv),
  .err_n_out (err_n_out),
  .err_drv   (err_drv)
);

// File: tb/tb_bidir_parity_xcvr.sv
module tb_bidir_parity_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  typedef struct packed {
    logic [3:0]   drv;   // a, b, par, err
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         par;
    logic         err;
    logic [3:0]   req;   // requirement number for messages
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         oe_n, dir, odd_sel, par_in;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drv, b_drv, par_out, par_drv, err_n_out, err_drv;

  int   checks = 0;
  int   errors = 0;
  exp_t scb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_parity_xcvr #(.W(W), .STAGES(1)) dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .par_in(par_in), .par_out(par_out), .par_drv(par_drv),
    .err_n_out(err_n_out), .err_drv(err_drv)
  );

  function automatic logic ones_odd(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: set inputs between edges and push the expected outcome
  task automatic apply(input logic o, input logic d, input logic s, input logic p,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] r);
    exp_t e;
    @(negedge clk);
    oe_n = o; dir = d; odd_sel = s; par_in = p; a_in = a; b_in = b;
    e = '0;
    e.req = r;
    if (!o && d) begin
      e.drv   = 4'b0110;
      e.b_out = a;
      e.par   = s ^ ones_odd(a);
    end else if (!o) begin
      e.drv   = 4'b1001;
      e.a_out = b;
      e.err   = ~(ones_odd(b) ^ p ^ s);
    end
    scb.push_back(e);
  endtask

  // monitor: one result per cycle, sampled shortly after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (scb.size() > 0) begin
        exp_t e;
        e = scb.pop_front();
        check($sformatf("R%0d drv", e.req), {a_drv, b_drv, par_drv, err_drv}, e.drv);
        check("R7 exclusive", (a_drv & b_drv) | (par_drv & err_drv), 0);
        if (e.drv[2]) check($sformatf("R%0d b_out", e.req), b_out, e.b_out);
        if (e.drv[3]) check($sformatf("R%0d a_out", e.req), a_out, e.a_out);
        if (e.drv[1]) check($sformatf("R%0d par_out", e.req), par_out, e.par);
        if (e.drv[0]) check($sformatf("R%0d err_n_out", e.req), err_n_out, e.err);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; dir = 1'b1; odd_sel = 1'b1; par_in = 1'b0;
    a_in = 8'hA5; b_in = 8'h3C;
    repeat (3) @(negedge clk);
    check("R8 reset drv", {a_drv, b_drv, par_drv, err_drv}, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R4: every A byte, both parity senses, parity input toggling
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 256; v++)
        apply(1'b0, 1'b1, s[0], v[3], v[7:0], ~v[7:0], (v % 2) ? 4'd4 : 4'd1);

    // R2 / R5: every B byte with all four select/parity pairs
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 256; v++)
        apply(1'b0, 1'b0, c[1], c[0], v[7:0] ^ 8'h5A, v[7:0], (v % 2) ? 4'd5 : 4'd2);

    // R6: fixed receive examples
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h03, 4'd6);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h07, 4'd6);

    // R3: disabled, other inputs moving in both directions
    for (int v = 0; v < 16; v++)
      apply(1'b1, v[0], v[1], v[2], v[7:0] * 8'd17, ~(v[7:0] * 8'd13), 4'd3);

    // R8: back-to-back direction flips show one-cycle latency
    for (int v = 0; v < 8; v++)
      apply(1'b0, v[0], 1'b0, 1'b0, 8'hF0 + v[7:0], 8'h0F + v[7:0], 4'd8);

    repeat (3) @(negedge clk);
    // R8: reset between edges drops drives at once
    #3 rst_n = 1'b0;
    #1 check("R8 async reset drv", {a_drv, b_drv, par_drv, err_drv}, 4'b0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    oe_n = 1'b0; dir = 1'b0;
    @(negedge clk);
    check("R8 sync release drv", {a_drv, b_drv, par_drv, err_drv}, 4'b0000);
    repeat (2) @(negedge clk);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'h00, 4'd8);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hE7, 4'd8);

    repeat (4) @(negedge clk);
    report();
  end

endmodule